// File: doc/BRIEF.md
# Depth-First Spare Allocation Engine

This block decides, on chip, which spare rows and spare columns should replace faulty cells of a memory array. A separate march-test controller streams fault reports to it. Each report carries a row address, a column address and the index of the march element that found it. The engine builds its repair decisions online as a depth-first search. Every fault that no spare on the current path already covers opens a new decision, and the row choice is tried before the column choice. The engine keeps only the chain of decisions, never a map of all failing cells. To explore an alternative it asks the test controller to rerun the test from the march element where the fault at the turning point was found.

One run begins with a pulse on `start`. The engine then requests a test pass from element 0 and consumes faults until the controller signals the end of the pass. Each time a pass completes with every fault covered, the current decision chain becomes the best solution. The engine then keeps searching for a chain that uses fewer spares. A path is abandoned as soon as a spare of the needed kind is missing or the path can no longer beat the best count. When the column alternative of the first decision has been explored, the engine reports the smallest repair it found, or it flags the memory as not repairable.

The control is a five-state machine. IDLE waits for `start`. LAUNCH pulses the restart request. COLLECT consumes faults until the pass ends or the path fails. RETREAT unwinds the decision chain one entry per cycle. DONE holds the result. The transitions are: IDLE to LAUNCH on start; LAUNCH to COLLECT always; COLLECT to RETREAT on a path failure or on the end of a pass; RETREAT to LAUNCH when a decision is turned to its column branch; RETREAT to DONE when the chain is empty; DONE to LAUNCH on a new start. While in RETREAT, a decision that cannot be turned is removed and the engine stays in RETREAT.

Top module: `dfsa_engine`

## Requirements
- R1: While reset is active and after its release, `done`, `restart_req` and `not_repairable` are 0, and both result counts are 0.
- R2: A `start` sampled in the idle or finished state raises `restart_req` for exactly one cycle in the following cycle, with `restart_elem` = 0. The search state and the previous result are cleared at the same time.
- R3: A fault whose row equals a row spared on the current path, or whose column equals a column spared on the current path, allocates nothing.
- R4: An uncovered fault takes a spare row while any is free. It takes a spare column only when the rows are used up. When two solutions have the same total, the one found first (the row-first one) is kept.
- R5: Each restart after the first one names the march element recorded with the decision that was just switched from row to column. Restarts happen only at such switches.
- R6: A path is abandoned when an uncovered fault finds no free spare of either kind, or when taking one more spare would reach the best total found so far. The reported result is the smallest total over all paths.
- R7: If no path covers every fault, `not_repairable` is 1 with `done` and both counts are 0. With no faults at all, the result is repairable with zero spares.
- R8: While `done` is 1 and no `start` arrives, the fault and end-of-pass inputs have no effect. `done` stays 1, no restart is requested and the results stay stable.
- R9: Replaced rows are packed into `best_rows` and replaced columns into `best_cols` in allocation order. Slot 0 is bits [W-1:0], unused slots are zero, and the counts never exceed the number of spares of their kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new analysis (idle or finished state only) |
| fault_valid | input | 1 | A fault report is present this cycle |
| fault_row | input | ROW_W | Row address of the fault |
| fault_col | input | COL_W | Column address of the fault |
| fault_elem | input | ELEM_W | March element index that found the fault |
| test_done | input | 1 | The current test pass has finished |
| restart_req | output | 1 | One-cycle request to (re)start the test |
| restart_elem | output | ELEM_W | March element at which the test must restart |
| done | output | 1 | Analysis finished, results valid |
| not_repairable | output | 1 | No repair within the available spares |
| best_rows | output | NR*ROW_W | Replaced rows, packed, slot 0 lowest |
| best_row_cnt | output | clog2(NR+1) | Number of replaced rows |
| best_cols | output | NC*COL_W | Replaced columns, packed, slot 0 lowest |
| best_col_cnt | output | clog2(NC+1) | Number of replaced columns |

## Verification
Some properties are checked on every cycle. The restart request is a single-cycle pulse, and it stays silent while a result is held. The finished state persists until the next start, and the held counts do not move while in it. The not-repairable flag comes only with `done` and empty counts, and the counts never exceed the spares. Other behaviour shows only in the bench's scenarios against a model of the test controller. These are the sequence of restart elements, the rule that covered faults are ignored, the row-first order, the search for a smaller total, and the packed repair lists. The scenarios are a clustered row, a clustered column, diagonal faults that need every spare, one fault too many, and an empty pass.

// File: rtl/dfsa_pkg.sv
`timescale 1ns/1ps
package dfsa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_COLLECT,
        ST_RETREAT,
        ST_DONE
    } dfsa_state_t;

    typedef enum logic [1:0] {
        STK_HOLD,
        STK_PUSH,
        STK_FLIP,
        STK_POP
    } stk_op_t;

endpackage

// File: rtl/dfsa_stack.sv
`timescale 1ns/1ps
// Decision chain: one entry per allocated spare, with coverage lookup.
module dfsa_stack
    import dfsa_pkg::*;
#(
    parameter int NR    = 2,
    parameter int NC    = 2,
    parameter int RW    = 4,
    parameter int CW    = 4,
    parameter int EW    = 3,
    parameter int TOT   = NR + NC,
    parameter int DW    = $clog2(TOT + 2)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  stk_op_t                  op,
    input  logic [RW-1:0]            in_row,
    input  logic [CW-1:0]            in_col,
    input  logic [EW-1:0]            in_elem,
    input  logic                     in_is_col,
    input  logic [RW-1:0]            q_row,
    input  logic [CW-1:0]            q_col,
    output logic                     covered,
    output logic [DW-1:0]            depth,
    output logic [DW-1:0]            rows_used,
    output logic [DW-1:0]            cols_used,
    output logic [EW-1:0]            top_elem,
    output logic                     top_is_col,
    output logic [TOT-1:0][RW-1:0]   stk_row,
    output logic [TOT-1:0][CW-1:0]   stk_col,
    output logic [TOT-1:0]           stk_is_col
);

    logic [TOT-1:0][EW-1:0] stk_elem;

    // A fault is covered when any live entry spares its row or its column.
    always_comb begin
        covered = 1'b0;
        for (int i = 0; i < TOT; i++) begin
            if (i < int'(depth)) begin
                if (stk_is_col[i] && stk_col[i] == q_col) covered = 1'b1;
                if (!stk_is_col[i] && stk_row[i] == q_row) covered = 1'b1;
            end
        end
    end

    always_comb begin
        top_elem   = '0;
        top_is_col = 1'b0;
        for (int i = 0; i < TOT; i++) begin
            if (i + 1 == int'(depth)) begin
                top_elem   = stk_elem[i];
                top_is_col = stk_is_col[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth      <= '0;
            rows_used  <= '0;
            cols_used  <= '0;
            stk_row    <= '0;
            stk_col    <= '0;
            stk_elem   <= '0;
            stk_is_col <= '0;
        end else if (clr) begin
            depth      <= '0;
            rows_used  <= '0;
            cols_used  <= '0;
            stk_row    <= '0;
            stk_col    <= '0;
            stk_elem   <= '0;
            stk_is_col <= '0;
        end else begin
            unique case (op)
                STK_HOLD: ;
                STK_PUSH: begin
                    for (int i = 0; i < TOT; i++) begin
                        if (i == int'(depth)) begin
                            stk_row[i]    <= in_row;
                            stk_col[i]    <= in_col;
                            stk_elem[i]   <= in_elem;
                            stk_is_col[i] <= in_is_col;
                        end
                    end
                    depth <= depth + DW'(1);
                    if (in_is_col) cols_used <= cols_used + DW'(1);
                    else           rows_used <= rows_used + DW'(1);
                end
                STK_FLIP: begin
                    for (int i = 0; i < TOT; i++) begin
                        if (i + 1 == int'(depth)) stk_is_col[i] <= 1'b1;
                    end
                    rows_used <= rows_used - DW'(1);
                    cols_used <= cols_used + DW'(1);
                end
                STK_POP: begin
                    depth <= depth - DW'(1);
                    if (top_is_col) cols_used <= cols_used - DW'(1);
                    else            rows_used <= rows_used - DW'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/dfsa_best.sv
`timescale 1ns/1ps
// Holds the smallest complete repair found so far, packed into row/column lists.
module dfsa_best #(
    parameter int NR    = 2,
    parameter int NC    = 2,
    parameter int RW    = 4,
    parameter int CW    = 4,
    parameter int TOT   = NR + NC,
    parameter int DW    = $clog2(TOT + 2),
    parameter int RCW   = $clog2(NR + 1),
    parameter int CCW   = $clog2(NC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     capture,
    input  logic [DW-1:0]            depth,
    input  logic [TOT-1:0][RW-1:0]   stk_row,
    input  logic [TOT-1:0][CW-1:0]   stk_col,
    input  logic [TOT-1:0]           stk_is_col,
    output logic [DW-1:0]            best_cnt,
    output logic                     best_valid,
    output logic [NR*RW-1:0]         best_rows,
    output logic [RCW-1:0]           best_row_cnt,
    output logic [NC*CW-1:0]         best_cols,
    output logic [CCW-1:0]           best_col_cnt
);

    localparam logic [DW-1:0] NO_BEST = DW'(TOT + 1);

    logic [NR*RW-1:0] rows_n;
    logic [NC*CW-1:0] cols_n;
    int               rn_c;
    int               cn_c;

    always_comb begin
        rows_n = '0;
        cols_n = '0;
        rn_c   = 0;
        cn_c   = 0;
        for (int i = 0; i < TOT; i++) begin
            if (i < int'(depth)) begin
                if (stk_is_col[i]) begin
                    if (cn_c < NC) cols_n[cn_c*CW +: CW] = stk_col[i];
                    cn_c = cn_c + 1;
                end else begin
                    if (rn_c < NR) rows_n[rn_c*RW +: RW] = stk_row[i];
                    rn_c = rn_c + 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_cnt     <= NO_BEST;
            best_valid   <= 1'b0;
            best_rows    <= '0;
            best_cols    <= '0;
            best_row_cnt <= '0;
            best_col_cnt <= '0;
        end else if (clr) begin
            best_cnt     <= NO_BEST;
            best_valid   <= 1'b0;
            best_rows    <= '0;
            best_cols    <= '0;
            best_row_cnt <= '0;
            best_col_cnt <= '0;
        end else if (capture) begin
            best_cnt     <= depth;
            best_valid   <= 1'b1;
            best_rows    <= rows_n;
            best_cols    <= cols_n;
            best_row_cnt <= RCW'(rn_c);
            best_col_cnt <= CCW'(cn_c);
        end
    end

endmodule

// File: rtl/dfsa_engine.sv
`timescale 1ns/1ps
// Depth-first spare allocation: top-level control.
module dfsa_engine
    import dfsa_pkg::*;
#(
    parameter int NR     = 2,
    parameter int NC     = 2,
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int ELEM_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          fault_valid,
    input  logic [ROW_W-1:0]              fault_row,
    input  logic [COL_W-1:0]              fault_col,
    input  logic [ELEM_W-1:0]             fault_elem,
    input  logic                          test_done,
    output logic                          restart_req,
    output logic [ELEM_W-1:0]             restart_elem,
    output logic                          done,
    output logic                          not_repairable,
    output logic [NR*ROW_W-1:0]           best_rows,
    output logic [$clog2(NR+1)-1:0]       best_row_cnt,
    output logic [NC*COL_W-1:0]           best_cols,
    output logic [$clog2(NC+1)-1:0]       best_col_cnt
);

    localparam int TOT = NR + NC;
    localparam int DW  = $clog2(TOT + 2);
    localparam logic [DW-1:0] NR_L = DW'(NR);
    localparam logic [DW-1:0] NC_L = DW'(NC);

    dfsa_state_t state, state_n;
    logic [ELEM_W-1:0] launch_elem, launch_n;

    stk_op_t                  op;
    logic                     clr;
    logic                     capture;
    logic                     new_is_col;
    logic                     covered;
    logic [DW-1:0]            depth, rows_used, cols_used, best_cnt;
    logic [ELEM_W-1:0]        top_elem;
    logic                     top_is_col;
    logic [TOT-1:0][ROW_W-1:0] stk_row;
    logic [TOT-1:0][COL_W-1:0] stk_col;
    logic [TOT-1:0]           stk_is_col;
    logic                     best_valid;

    logic row_free, col_free, bound_ok, can_flip;

    dfsa_stack #(
        .NR(NR), .NC(NC), .RW(ROW_W), .CW(COL_W), .EW(ELEM_W)
    ) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .op         (op),
        .in_row     (fault_row),
        .in_col     (fault_col),
        .in_elem    (fault_elem),
        .in_is_col  (new_is_col),
        .q_row      (fault_row),
        .q_col      (fault_col),
        .covered    (covered),
        .depth      (depth),
        .rows_used  (rows_used),
        .cols_used  (cols_used),
        .top_elem   (top_elem),
        .top_is_col (top_is_col),
        .stk_row    (stk_row),
        .stk_col    (stk_col),
        .stk_is_col (stk_is_col)
    );

    dfsa_best #(
        .NR(NR), .NC(NC), .RW(ROW_W), .CW(COL_W)
    ) u_best (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .capture      (capture),
        .depth        (depth),
        .stk_row      (stk_row),
        .stk_col      (stk_col),
        .stk_is_col   (stk_is_col),
        .best_cnt     (best_cnt),
        .best_valid   (best_valid),
        .best_rows    (best_rows),
        .best_row_cnt (best_row_cnt),
        .best_cols    (best_cols),
        .best_col_cnt (best_col_cnt)
    );

    assign row_free = rows_used < NR_L;
    assign col_free = cols_used < NC_L;
    assign bound_ok = (depth + DW'(1)) < best_cnt;
    assign can_flip = !top_is_col && col_free && (depth < best_cnt);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            launch_elem <= '0;
        end else begin
            state       <= state_n;
            launch_elem <= launch_n;
        end
    end

    // Transitions and datapath control
    always_comb begin
        state_n    = state;
        launch_n   = launch_elem;
        op         = STK_HOLD;
        clr        = 1'b0;
        capture    = 1'b0;
        new_is_col = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    clr      = 1'b1;
                    launch_n = '0;
                    state_n  = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                state_n = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (fault_valid && !covered) begin
                    if (!bound_ok) begin
                        state_n = ST_RETREAT;
                    end else if (row_free) begin
                        op = STK_PUSH;
                    end else if (col_free) begin
                        op         = STK_PUSH;
                        new_is_col = 1'b1;
                    end else begin
                        state_n = ST_RETREAT;
                    end
                end else if (!fault_valid && test_done) begin
                    capture = 1'b1;
                    state_n = ST_RETREAT;
                end
            end
            ST_RETREAT: begin
                if (depth == '0) begin
                    state_n = ST_DONE;
                end else if (can_flip) begin
                    op       = STK_FLIP;
                    launch_n = top_elem;
                    state_n  = ST_LAUNCH;
                end else begin
                    op = STK_POP;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        restart_req    = (state == ST_LAUNCH);
        restart_elem   = launch_elem;
        done           = (state == ST_DONE);
        not_repairable = (state == ST_DONE) && !best_valid;
    end

endmodule

// File: rtl/dfsa_engine_chk.sv
`timescale 1ns/1ps
module dfsa_engine_chk #(
    parameter int NR  = 2,
    parameter int NC  = 2,
    parameter int RCW = $clog2(NR + 1),
    parameter int CCW = $clog2(NC + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           restart_req,
    input logic           done,
    input logic           not_repairable,
    input logic [RCW-1:0] best_row_cnt,
    input logic [CCW-1:0] best_col_cnt
);

    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req); // R2

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !restart_req); // R8

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R8

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> ($stable(best_row_cnt) && $stable(best_col_cnt))); // R8

    AST_NR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        not_repairable |-> done); // R7

    AST_NR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        not_repairable |-> (best_row_cnt == '0 && best_col_cnt == '0)); // R7

    AST_ROW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        best_row_cnt <= RCW'(NR)); // R9

    AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        best_col_cnt <= CCW'(NC)); // R9

endmodule

bind dfsa_engine dfsa_engine_chk #(.NR(NR), .NC(NC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .restart_req    (restart_req),
    .done           (done),
    .not_repairable (not_repairable),
    .best_row_cnt   (best_row_cnt),
    .best_col_cnt   (best_col_cnt)
);

// File: tb/dfsa_engine_tb_top.sv
`timescale 1ns/1ps
module dfsa_engine_tb_top;

    localparam int NR  = 2;
    localparam int NC  = 2;
    localparam int RW  = 4;
    localparam int CW  = 4;
    localparam int EW  = 3;
    localparam int RCW = $clog2(NR + 1);
    localparam int CCW = $clog2(NC + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              fault_valid = 1'b0;
    logic [RW-1:0]     fault_row = '0;
    logic [CW-1:0]     fault_col = '0;
    logic [EW-1:0]     fault_elem = '0;
    logic              test_done = 1'b0;
    logic              restart_req;
    logic [EW-1:0]     restart_elem;
    logic              done;
    logic              not_repairable;
    logic [NR*RW-1:0]  best_rows;
    logic [RCW-1:0]    best_row_cnt;
    logic [NC*CW-1:0]  best_cols;
    logic [CCW-1:0]    best_col_cnt;

    always #2.5 clk = ~clk;

    dfsa_engine #(.NR(NR), .NC(NC), .ROW_W(RW), .COL_W(CW), .ELEM_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .fault_valid(fault_valid), .fault_row(fault_row), .fault_col(fault_col),
        .fault_elem(fault_elem), .test_done(test_done),
        .restart_req(restart_req), .restart_elem(restart_elem),
        .done(done), .not_repairable(not_repairable),
        .best_rows(best_rows), .best_row_cnt(best_row_cnt),
        .best_cols(best_cols), .best_col_cnt(best_col_cnt)
    );

    int checks = 0;
    int failures = 0;

    // Fault list replayed by the test-controller model
    logic [RW-1:0] fl_row [8];
    logic [CW-1:0] fl_col [8];
    logic [EW-1:0] fl_elem[8];
    int            fl_n = 0;

    typedef struct packed {
        logic [NR*RW-1:0] rows;
        logic [RCW-1:0]   rc;
        logic [NC*CW-1:0] cols;
        logic [CCW-1:0]   cc;
        logic             nr;
    } res_t;

    res_t          q_res[$];
    logic [EW-1:0] q_rst[$];
    bit            chk_rst = 1'b0;
    string         cur_tag = "R1";

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic add_fault(logic [RW-1:0] r, logic [CW-1:0] c, logic [EW-1:0] e);
        fl_row[fl_n]  = r;
        fl_col[fl_n]  = c;
        fl_elem[fl_n] = e;
        fl_n++;
    endtask

    task automatic expect_result(logic [NR*RW-1:0] r, logic [RCW-1:0] rc,
                                 logic [NC*CW-1:0] c, logic [CCW-1:0] cc, logic nr);
        res_t x;
        x.rows = r; x.rc = rc; x.cols = c; x.cc = cc; x.nr = nr;
        q_res.push_back(x);
    endtask

    // Driver: launch one analysis and wait for its result
    task automatic run_case(string tag, bit use_rst);
        cur_tag = tag;
        chk_rst = use_rst;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R2 launch pulse"}, {31'd0, restart_req}, 32'd1);
        check({tag, " R2 launch element"}, {29'd0, restart_elem}, 32'd0);
        while (!done) @(negedge clk);
        @(negedge clk);
        if (use_rst) check({tag, " R5 restart sequence consumed"}, q_rst.size(), 32'd0);
        check({tag, " result consumed"}, q_res.size(), 32'd0);
        q_rst.delete();
    endtask

    // Test-controller model: replays faults from the requested element on
    initial begin
        int            pos;
        logic [EW-1:0] from;
        bit            active;
        bit            pend;
        pos = 0; from = '0; active = 1'b0; pend = 1'b0;
        forever begin
            @(negedge clk);
            if (active || pend) begin
                fault_valid = 1'b0;
                test_done   = 1'b0;
                pend        = 1'b0;
            end
            if (restart_req) begin
                active = 1'b1;
                pos    = 0;
                from   = restart_elem;
            end else if (active) begin
                while (pos < fl_n && fl_elem[pos] < from) pos++;
                if (pos < fl_n) begin
                    fault_valid = 1'b1;
                    fault_row   = fl_row[pos];
                    fault_col   = fl_col[pos];
                    fault_elem  = fl_elem[pos];
                    pos++;
                end else begin
                    test_done = 1'b1;
                    active    = 1'b0;
                    pend      = 1'b1;
                end
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        bit            prev_done;
        bit            prev_rq;
        logic [EW-1:0] e;
        res_t          x;
        prev_done = 1'b0; prev_rq = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (restart_req && prev_rq)
                    check({cur_tag, " R2 restart longer than one cycle"}, 32'd2, 32'd1);
                if (restart_req && chk_rst) begin
                    if (q_rst.size() == 0) begin
                        check({cur_tag, " R5 unexpected restart"}, {29'd0, restart_elem}, 32'hFFFF);
                    end else begin
                        e = q_rst.pop_front();
                        check({cur_tag, " R5 restart element"}, {29'd0, restart_elem}, {29'd0, e});
                    end
                end
                if (done && !prev_done) begin
                    if (q_res.size() == 0) begin
                        check({cur_tag, " unexpected result"}, 32'd1, 32'd0);
                    end else begin
                        x = q_res.pop_front();
                        check({cur_tag, " R9 row list"},  {24'd0, best_rows}, {24'd0, x.rows});
                        check({cur_tag, " R6 row count"}, {30'd0, best_row_cnt}, {30'd0, x.rc});
                        check({cur_tag, " R9 column list"}, {24'd0, best_cols}, {24'd0, x.cols});
                        check({cur_tag, " R6 column count"}, {30'd0, best_col_cnt}, {30'd0, x.cc});
                        check({cur_tag, " R7 not-repairable flag"}, {31'd0, not_repairable}, {31'd0, x.nr});
                    end
                end
            end
            prev_done = done;
            prev_rq   = restart_req;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 done in reset", {31'd0, done}, 32'd0);
        check("R1 restart_req in reset", {31'd0, restart_req}, 32'd0);
        check("R1 flag in reset", {31'd0, not_repairable}, 32'd0);
        check("R1 counts in reset", {30'd0, best_row_cnt} + {30'd0, best_col_cnt}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle after reset", {30'd0, done, restart_req}, 32'd0);

        // R3/R4: faults along one row, single row spare wins
        fl_n = 0;
        add_fault(4'd1, 4'd3, 3'd0);
        add_fault(4'd1, 4'd7, 3'd0);
        add_fault(4'd1, 4'd9, 3'd1);
        q_rst.push_back(3'd0);
        expect_result(8'h01, 2'd1, 8'h00, 2'd0, 1'b0);
        run_case("R3 R4 row cluster", 1'b1);

        // R5/R6: column cluster, search shrinks to a single column
        fl_n = 0;
        add_fault(4'd1, 4'd5, 3'd0);
        add_fault(4'd2, 4'd5, 3'd1);
        add_fault(4'd3, 4'd5, 3'd2);
        q_rst.push_back(3'd0);
        q_rst.push_back(3'd1);
        q_rst.push_back(3'd0);
        expect_result(8'h00, 2'd0, 8'h05, 2'd1, 1'b0);
        run_case("R5 R6 column cluster", 1'b1);

        // R4/R9: diagonal needs every spare, first-found allocation order kept
        fl_n = 0;
        add_fault(4'd1, 4'd1, 3'd0);
        add_fault(4'd2, 4'd2, 3'd1);
        add_fault(4'd3, 4'd3, 3'd2);
        add_fault(4'd4, 4'd4, 3'd3);
        expect_result(8'h21, 2'd2, 8'h43, 2'd2, 1'b0);
        run_case("R4 R9 diagonal", 1'b0);

        // R8: inputs while finished have no effect
        cur_tag = "R8";
        for (int k = 0; k < 4; k++) begin
            fault_valid = (k < 3);
            fault_row   = 4'd7;
            fault_col   = 4'd7;
            test_done   = (k == 3);
            @(negedge clk);
            check("R8 done held", {31'd0, done}, 32'd1);
            check("R8 no restart while done", {31'd0, restart_req}, 32'd0);
        end
        fault_valid = 1'b0;
        test_done   = 1'b0;
        @(negedge clk);
        check("R8 rows unchanged", {24'd0, best_rows}, 32'h21);
        check("R8 columns unchanged", {24'd0, best_cols}, 32'h43);

        // R6/R7: one fault beyond the spares
        fl_n = 0;
        add_fault(4'd1, 4'd1, 3'd0);
        add_fault(4'd2, 4'd2, 3'd1);
        add_fault(4'd3, 4'd3, 3'd2);
        add_fault(4'd4, 4'd4, 3'd3);
        add_fault(4'd5, 4'd5, 3'd3);
        expect_result(8'h00, 2'd0, 8'h00, 2'd0, 1'b1);
        run_case("R6 R7 too many faults", 1'b0);

        // R7: empty pass is repairable with no spares
        fl_n = 0;
        q_rst.push_back(3'd0);
        expect_result(8'h00, 2'd0, 8'h00, 2'd0, 1'b0);
        run_case("R7 no faults", 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule